// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Transmitter

This block turns a 24-bit frame word into an infrared pulse-distance waveform and modulates it onto a carrier that drives an LED. A transmission begins with a long burst of carrier. An optional carrier-off gap may follow. Each bit then goes out as a carrier mark followed by a dark space, and the length of that space encodes the bit. One closing mark ends the last space, so the receiver can measure the final space.

Every segment length is a whole number of base periods. The base period is a configurable count of clock cycles, and each kind of segment has its own multiplier. A gap multiplier of zero drops the gap entirely. The carrier comes from a counter with a configurable period and high time, both in clock cycles. Typical settings are a carrier between 30 and 45 kHz (38 kHz by default), a duty cycle between 25 and 75 % (50 % by default), and a base period between 300 and 1000 µs (600 µs by default).

The frame arrives already packed: a 3-bit type, an 8-bit identifier, a 5-bit amount and an 8-bit check byte. The configuration inputs must stay constant while the block is busy.

Top module: `irpd_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `led_o`, `busy_o` and `done_o` are all 0.
- R2: The cycle after the idle block samples `start_i` high, `busy_o` rises and the envelope (carrier enabled) stays on for `start_mul_i` × `base_cyc_i` cycles.
- R3: After the start burst, the envelope stays off for `gap_mul_i` × `base_cyc_i` cycles. When `gap_mul_i` is 0, the first mark follows the burst directly.
- R4: Every mark, the closing mark included, keeps the envelope on for `mark_mul_i` × `base_cyc_i` cycles.
- R5: Bits go out from `frame_i[23]` down to `frame_i[0]`, each as a mark followed by a space. The space lasts `sp0_mul_i` × `base_cyc_i` cycles for a 0 bit and `sp1_mul_i` × `base_cyc_i` cycles for a 1 bit.
- R6: A closing mark follows the 24th space. In the cycle after that mark's last cycle, `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R7: A high `start_i` while `busy_o` is 1 is ignored: the frame in flight and its timing are unchanged, and so is the frame latched at start.
- R8: The carrier counter restarts with each accepted start. The carrier is high for the first `car_high_i` cycles of every `car_period_i`-cycle period, and with `car_high_i` ≥ `car_period_i` it is always high.
- R9: `led_o` is the AND of the carrier and the envelope, so it stays 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| frame_i | input | 24 | Frame word, MSB sent first |
| base_cyc_i | input | 16 | Clock cycles per base period |
| start_mul_i | input | 4 | Start burst length in base periods |
| gap_mul_i | input | 4 | Gap length in base periods, 0 drops the gap |
| mark_mul_i | input | 4 | Mark length in base periods |
| sp0_mul_i | input | 4 | Space length for a 0 bit, in base periods |
| sp1_mul_i | input | 4 | Space length for a 1 bit, in base periods |
| car_period_i | input | 12 | Carrier period in clock cycles |
| car_high_i | input | 12 | Carrier high time in clock cycles |
| led_o | output | 1 | Modulated LED drive |
| busy_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-cycle pulse after the closing mark |

## Verification
The bench sweeps start and mark multipliers, gap multipliers including zero, and several pairs of space multipliers. The frames are all zeros, all ones, alternating patterns and a packed field frame. Comparing the LED cycle by cycle against a waveform built arithmetically tells bit order and space selection apart from segment-length errors. Further runs at 25, 50 and 75 % duty and at an odd carrier period separate carrier phase and duty errors from envelope errors. A start strobe with an inverted frame in mid-transmission shows whether a busy start is truly ignored.

// File: rtl/irpd_pkg.sv
package irpd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_GAP,
    ST_MARK,
    ST_SPACE
  } irpd_state_e;

  // Typical multiplier settings
  localparam int DEF_START_MUL = 4;
  localparam int DEF_GAP_MUL   = 1;
  localparam int DEF_MARK_MUL  = 1;
  localparam int DEF_SP0_MUL   = 1;
  localparam int DEF_SP1_MUL   = 2;
endpackage

// File: rtl/irpd_timer.sv
module irpd_timer #(
  parameter int BASE_W = 16,
  parameter int MUL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MUL_W-1:0]  units_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              last_o
);
  localparam logic [BASE_W-1:0] B_ONE = BASE_W'(1);
  localparam logic [MUL_W-1:0]  U_ONE = MUL_W'(1);

  logic [BASE_W-1:0] bcnt_q, bcnt_d;
  logic [MUL_W-1:0]  ucnt_q, ucnt_d;

  assign last_o = (bcnt_q == '0) && (ucnt_q == '0);

  always_comb begin
    bcnt_d = bcnt_q;
    ucnt_d = ucnt_q;
    if (load_i) begin
      bcnt_d = base_i - B_ONE;
      ucnt_d = units_i - U_ONE;
    end else if (bcnt_q == '0) begin
      if (ucnt_q != '0) begin
        ucnt_d = ucnt_q - U_ONE;
        bcnt_d = base_i - B_ONE;
      end
    end else begin
      bcnt_d = bcnt_q - B_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      ucnt_q <= '0;
    end else begin
      bcnt_q <= bcnt_d;
      ucnt_q <= ucnt_d;
    end
  end

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !last_o) |=> (ucnt_q <= $past(ucnt_q))); // R4
endmodule

// File: rtl/irpd_carrier.sv
module irpd_carrier #(
  parameter int CAR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CAR_W-1:0] period_i,
  input  logic [CAR_W-1:0] high_i,
  output logic             car_o
);
  localparam logic [CAR_W-1:0] C_ONE = CAR_W'(1);

  logic [CAR_W-1:0] cnt_q, cnt_d;

  assign car_o = (cnt_q < high_i);

  always_comb begin
    if (restart_i || (cnt_q >= period_i - C_ONE)) cnt_d = '0;
    else                                          cnt_d = cnt_q + C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CAR_PHASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && high_i != '0) |=> car_o); // R8
endmodule

// File: rtl/irpd_seq.sv
module irpd_seq
  import irpd_pkg::*;
#(
  parameter int NBITS = 24,
  parameter int MUL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBITS-1:0] frame_i,
  input  logic [MUL_W-1:0] start_mul_i,
  input  logic [MUL_W-1:0] gap_mul_i,
  input  logic [MUL_W-1:0] mark_mul_i,
  input  logic [MUL_W-1:0] sp0_mul_i,
  input  logic [MUL_W-1:0] sp1_mul_i,
  input  logic             tmr_last_i,
  output logic             tmr_load_o,
  output logic [MUL_W-1:0] tmr_units_o,
  output logic             car_restart_o,
  output logic             env_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int BIDX_W = $clog2(NBITS + 1);
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(NBITS);
  localparam logic [BIDX_W-1:0] I_ONE    = BIDX_W'(1);

  irpd_state_e       state_q, state_d;
  logic [NBITS-1:0]  sh_q, sh_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              done_q, done_d;

  always_comb begin
    state_d       = state_q;
    sh_d          = sh_q;
    bidx_d        = bidx_q;
    done_d        = 1'b0;
    tmr_load_o    = 1'b0;
    tmr_units_o   = '0;
    car_restart_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d       = ST_START;
        sh_d          = frame_i;
        bidx_d        = '0;
        tmr_load_o    = 1'b1;
        tmr_units_o   = start_mul_i;
        car_restart_o = 1'b1;
      end
      ST_START: if (tmr_last_i) begin
        tmr_load_o = 1'b1;
        if (gap_mul_i == '0) begin
          state_d     = ST_MARK;
          tmr_units_o = mark_mul_i;
        end else begin
          state_d     = ST_GAP;
          tmr_units_o = gap_mul_i;
        end
      end
      ST_GAP: if (tmr_last_i) begin
        state_d     = ST_MARK;
        tmr_load_o  = 1'b1;
        tmr_units_o = mark_mul_i;
      end
      ST_MARK: if (tmr_last_i) begin
        if (bidx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d     = ST_SPACE;
          tmr_load_o  = 1'b1;
          tmr_units_o = sh_q[NBITS-1] ? sp1_mul_i : sp0_mul_i;
        end
      end
      ST_SPACE: if (tmr_last_i) begin
        state_d     = ST_MARK;
        sh_d        = {sh_q[NBITS-2:0], 1'b0};
        bidx_d      = bidx_q + I_ONE;
        tmr_load_o  = 1'b1;
        tmr_units_o = mark_mul_i;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bidx_q  <= bidx_d;
      done_q  <= done_d;
    end
  end

  assign env_o  = (state_q == ST_START) || (state_q == ST_MARK);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && state_q != ST_START) |=> (state_q != ST_START)); // R7
  AST_GAP_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tmr_last_i && gap_mul_i == '0) |=> (state_q == ST_MARK)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(state_q) == ST_MARK && !busy_o)); // R6
endmodule

// File: rtl/irpd_tx.sv
module irpd_tx #(
  parameter int NBITS  = 24,
  parameter int BASE_W = 16,
  parameter int MUL_W  = 4,
  parameter int CAR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NBITS-1:0]  frame_i,
  input  logic [BASE_W-1:0] base_cyc_i,
  input  logic [MUL_W-1:0]  start_mul_i,
  input  logic [MUL_W-1:0]  gap_mul_i,
  input  logic [MUL_W-1:0]  mark_mul_i,
  input  logic [MUL_W-1:0]  sp0_mul_i,
  input  logic [MUL_W-1:0]  sp1_mul_i,
  input  logic [CAR_W-1:0]  car_period_i,
  input  logic [CAR_W-1:0]  car_high_i,
  output logic              led_o,
  output logic              busy_o,
  output logic              done_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             tmr_load, tmr_last, car_restart, env, car;
  logic [MUL_W-1:0] tmr_units;

  irpd_seq #(.NBITS(NBITS), .MUL_W(MUL_W)) i_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_i),
    .frame_i       (frame_i),
    .start_mul_i   (start_mul_i),
    .gap_mul_i     (gap_mul_i),
    .mark_mul_i    (mark_mul_i),
    .sp0_mul_i     (sp0_mul_i),
    .sp1_mul_i     (sp1_mul_i),
    .tmr_last_i    (tmr_last),
    .tmr_load_o    (tmr_load),
    .tmr_units_o   (tmr_units),
    .car_restart_o (car_restart),
    .env_o         (env),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  irpd_timer #(.BASE_W(BASE_W), .MUL_W(MUL_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (tmr_load),
    .units_i (tmr_units),
    .base_i  (base_cyc_i),
    .last_o  (tmr_last)
  );

  irpd_carrier #(.CAR_W(CAR_W)) i_carrier (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (car_restart),
    .period_i  (car_period_i),
    .high_i    (car_high_i),
    .car_o     (car)
  );

  assign led_o = env & car;

  AST_LED_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> !led_o); // R9
endmodule

// File: tb/test_irpd_tx.sv
module test_irpd_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [23:0] frame_i;
  logic [15:0] base_cyc_i;
  logic [3:0]  start_mul_i, gap_mul_i, mark_mul_i, sp0_mul_i, sp1_mul_i;
  logic [11:0] car_period_i, car_high_i;
  logic        led_o, busy_o, done_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irpd_tx i_irpd_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .base_cyc_i(base_cyc_i), .start_mul_i(start_mul_i), .gap_mul_i(gap_mul_i),
    .mark_mul_i(mark_mul_i), .sp0_mul_i(sp0_mul_i), .sp1_mul_i(sp1_mul_i),
    .car_period_i(car_period_i), .car_high_i(car_high_i),
    .led_o(led_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
  endtask

  // Runs one frame and compares the LED against a computed waveform.
  // poke >= 0 raises start_i with an inverted frame at that sample index.
  task automatic run_frame(input logic [23:0] f, input int b, input int sm,
                           input int gm, input int mm, input int s0,
                           input int s1, input int p, input int h,
                           input int poke);
    logic env[$];
    int bad = 0, first = -1, side_bad = 0, t;
    base_cyc_i = 16'(b);  start_mul_i = 4'(sm); gap_mul_i = 4'(gm);
    mark_mul_i = 4'(mm);  sp0_mul_i = 4'(s0);   sp1_mul_i = 4'(s1);
    car_period_i = 12'(p); car_high_i = 12'(h); frame_i = f;
    for (int i = 0; i < sm*b; i++) env.push_back(1'b1);
    for (int i = 0; i < gm*b; i++) env.push_back(1'b0);
    for (int k = 23; k >= 0; k--) begin
      for (int i = 0; i < mm*b; i++) env.push_back(1'b1);
      for (int i = 0; i < (f[k] ? s1 : s0)*b; i++) env.push_back(1'b0);
    end
    for (int i = 0; i < mm*b; i++) env.push_back(1'b1);
    t = env.size();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < t; k++) begin
      logic e;
      e = env[k] && ((k % p) < h);
      if (led_o !== e) begin
        bad++;
        if (first < 0) first = k;
      end
      if (busy_o !== 1'b1 || done_o !== 1'b0) side_bad++;
      if (k == poke) begin
        start_i = 1'b1;
        frame_i = ~f;
      end else if (k == poke + 1) begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(bad == 0, "R2 R3 R4 R5 R8 R9", "led waveform mismatch count (first index shown as actual on error)",
        (bad == 0) ? 0 : first, 0);
    chk(side_bad == 0, "R2", "busy high and done low during frame, bad cycles", side_bad, 0);
    if (poke >= 0) chk(bad == 0 && side_bad == 0, "R7", "busy start disturbed frame", bad + side_bad, 0);
    chk(done_o === 1'b1, "R6", "done after closing mark", int'(done_o), 1);
    chk(busy_o === 1'b0, "R6", "busy cleared with done", int'(busy_o), 0);
    chk(led_o === 1'b0, "R9", "led dark when idle", int'(led_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R6", "done lasts one cycle", int'(done_o), 0);
    chk(led_o === 1'b0 && busy_o === 1'b0, "R9", "idle after frame", int'(led_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    logic [23:0] frames [4];
    frames[0] = 24'h000000;
    frames[1] = 24'hFFFFFF;
    frames[2] = 24'hA5C33C;
    frames[3] = {3'd1, 8'd42, 5'd23, 8'h71}; // type, id, amount, check byte
    rst_n = 1'b0; start_i = 1'b0; frame_i = '0;
    base_cyc_i = 16'd2; start_mul_i = 4'd4; gap_mul_i = 4'd1; mark_mul_i = 4'd1;
    sp0_mul_i = 4'd1; sp1_mul_i = 4'd2; car_period_i = 12'd4; car_high_i = 12'd2;
    repeat (3) @(negedge clk);
    chk(led_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1",
        "outputs in reset", {29'd0, led_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(led_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1",
        "outputs after release", {29'd0, led_o, busy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    chk(led_o === 1'b0, "R9", "idle led dark before any start", int'(led_o), 0);

    // Envelope sweep with constant carrier (high >= period)
    for (int gm = 0; gm <= 2; gm++)
      for (int sm = 2; sm <= 3; sm++)
        for (int mm = 1; mm <= 2; mm++)
          for (int fi = 0; fi < 4; fi++)
            run_frame(frames[fi], 2, sm, gm, mm, 1 + (fi % 3), 1 + ((fi + gm) % 4),
                      4, 4, -1);

    // Defaults, carrier duty variants, base of one cycle, wide multipliers
    run_frame(frames[3], 3, irpd_pkg::DEF_START_MUL, irpd_pkg::DEF_GAP_MUL,
              irpd_pkg::DEF_MARK_MUL, irpd_pkg::DEF_SP0_MUL, irpd_pkg::DEF_SP1_MUL,
              4, 2, -1);
    run_frame(frames[2], 3, 4, 1, 1, 1, 2, 4, 1, -1);
    run_frame(frames[2], 3, 4, 1, 1, 1, 2, 4, 3, -1);
    run_frame(frames[3], 2, 5, 0, 2, 3, 4, 5, 3, -1);
    run_frame(frames[2], 1, 8, 4, 2, 3, 4, 3, 2, -1);

    // Busy start ignored (R7)
    run_frame(frames[2], 2, 4, 1, 1, 1, 2, 4, 2, 5);
    run_frame(frames[3], 2, 3, 2, 1, 2, 3, 4, 4, 60);

    report();
    $finish;
  end
endmodule